// File: doc/BRIEF.md
# Echo-Checked Print Read Sequencer

This block steps a print line through a fixed schedule of 46 word positions. At some positions it takes a word from the channel and stores it in an external 24-entry row memory. At the others it sends a check word back to the channel, built as the bitwise AND of two stored rows, or as one stored row on its own. The words arrive in row order: rows 9 down to 1 take two words each (right half, then left half), followed by rows 10, 11 and 12. The echo words are sent at fixed points in that sequence, so the channel can confirm which hammer combinations were loaded.

A `go` pulse starts the block while it is idle. After the last echo word the block flags end of record, pulses `line_done` for one cycle and starts the next line at position 0. It keeps running like this until `chan_drop` aborts it. An abort also pulses `line_done`, so that the partial line is printed, and returns the block to idle at position 0.

Both data directions use valid/ready handshakes. Inbound, `rx_ready` is high only at read positions, and a word is taken on any cycle where `rx_valid` and `rx_ready` are both high. Outbound, `tx_valid` is high only at echo positions. `tx_data` stays fixed while `tx_ready` is low. The position counter moves only when a word is transferred.

Top module: `echo_read_seq`

## Requirements
- R1: After reset the block is idle: `rx_ready`, `tx_valid`, `mem_we`, `eor` and `line_done` are 0, and `echo_dir` is 0. While the block is idle these outputs stay 0.
- R2: A `go` pulse while idle starts a line at position 0. The first accepted word is written to slot 0.
- R3: At positions 0 to 17, each accepted word is written to the slot equal to the position (`mem_we`=1, `mem_slot`, `mem_wdata` = `rx_data`).
- R4: At position 18 the echo word is slot 2 AND slot 10. At position 19 it is slot 3 AND slot 11.
- R5: Positions 20 and 21 store into slots 18 and 19. The echo at position 22 is slot 12 AND slot 2, and at position 23 it is slot 13 AND slot 3.
- R6: Positions 24 and 25 store into slots 20 and 21. Positions 26 and 27 echo slot 0 and slot 1 unchanged.
- R7: Positions 28 and 29 store into slots 22 and 23. Positions 30 to 45 echo slot (position − 28) unchanged.
- R8: `echo_dir` (1 = block sends) rises after the word accepted at position 17, 21, 25 or 29. It falls after the echo at position 19, 23, 27 or 45. `rx_ready` is high only while `echo_dir`=0 and `tx_valid` only while `echo_dir`=1, never both at once.
- R9: While `tx_valid`=1 and `tx_ready`=0, `tx_valid` stays 1 and `tx_data` holds its value. The position advances only on a transfer.
- R10: `eor` is 1 exactly in the cycle in which the position-45 echo word is transferred.
- R11: In the cycle after the position-45 transfer, `line_done` is 1 and no handshake is offered. The next cycle reads position 0 again.
- R12: `chan_drop` while active makes `line_done` 1 in that cycle, blocks both handshakes, and returns the block to idle. A later `go` restarts at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start pulse, taken while idle |
| chan_drop | input | 1 | Channel disconnect, aborts the line |
| rx_valid | input | 1 | Inbound word valid |
| rx_ready | output | 1 | Inbound word accepted this cycle if valid |
| rx_data | input | DATA_W | Inbound word |
| mem_we | output | 1 | Row memory write strobe |
| mem_slot | output | 5 | Row memory write slot |
| mem_wdata | output | DATA_W | Row memory write data |
| mem_ra | output | 5 | First row memory read slot |
| mem_rb | output | 5 | Second row memory read slot |
| mem_da | input | DATA_W | Data at `mem_ra` (combinational) |
| mem_db | input | DATA_W | Data at `mem_rb` (combinational) |
| tx_valid | output | 1 | Echo word valid |
| tx_ready | input | 1 | Channel takes echo word |
| tx_data | output | DATA_W | Echo word |
| echo_dir | output | 1 | 1 while the block sends echo words |
| eor | output | 1 | End of record, with the last echo transfer |
| line_done | output | 1 | Print the buffered line |

## Verification
The assertions assume that the row memory returns, combinationally, the contents of the slots named on `mem_ra`/`mem_rb`, and that its contents change only through this block's write port. Under that assumption a stalled echo word can be checked as stable. The bench keeps to this by modelling the memory itself, written only by `mem_we`. It toggles `rx_valid` and `tx_ready` at random from a fixed seed, so stalls occur at every kind of position, and it drives `chan_drop` only at chosen points of the schedule.

// File: rtl/echo_seq_pkg.sv
package echo_seq_pkg;
  localparam int SLOT_W    = 5;
  localparam int POS_W     = 6;
  localparam int LAST_POS  = 45;
  localparam int PRINT_POS = 46;

  typedef struct packed {
    logic              send;   // position sources an echo word
    logic [SLOT_W-1:0] sa;     // store slot (read) or first operand (echo)
    logic [SLOT_W-1:0] sb;     // second echo operand
    logic              flip;   // direction changes after this transfer
  } step_t;

  function automatic step_t decode_step(input logic [POS_W-1:0] p);
    step_t s;
    int    n;
    n      = int'(p);
    s.send = 1'b1;
    s.flip = 1'b0;
    s.sa   = '0;
    s.sb   = '0;
    if (n <= 17) begin
      s.send = 1'b0;
      s.sa   = SLOT_W'(n);
      s.flip = (n == 17);
    end else begin
      case (n)
        18: begin s.sa = 5'd2;  s.sb = 5'd10; end
        19: begin s.sa = 5'd3;  s.sb = 5'd11; s.flip = 1'b1; end
        20: begin s.send = 1'b0; s.sa = 5'd18; end
        21: begin s.send = 1'b0; s.sa = 5'd19; s.flip = 1'b1; end
        22: begin s.sa = 5'd12; s.sb = 5'd2;  end
        23: begin s.sa = 5'd13; s.sb = 5'd3;  s.flip = 1'b1; end
        24: begin s.send = 1'b0; s.sa = 5'd20; end
        25: begin s.send = 1'b0; s.sa = 5'd21; s.flip = 1'b1; end
        26: begin s.sa = 5'd0;  s.sb = 5'd0;  end
        27: begin s.sa = 5'd1;  s.sb = 5'd1;  s.flip = 1'b1; end
        28: begin s.send = 1'b0; s.sa = 5'd22; end
        29: begin s.send = 1'b0; s.sa = 5'd23; s.flip = 1'b1; end
        default: begin
          s.sa   = SLOT_W'(n - 28);
          s.sb   = SLOT_W'(n - 28);
          s.flip = (n == LAST_POS);
        end
      endcase
    end
    return s;
  endfunction
endpackage

// File: rtl/echo_step_decode.sv
module echo_step_decode
  import echo_seq_pkg::*;
(
  input  logic [POS_W-1:0]  pos,
  output logic              send,
  output logic [SLOT_W-1:0] slot_a,
  output logic [SLOT_W-1:0] slot_b,
  output logic              flip
);
  step_t st;

  always_comb begin
    st     = decode_step(pos);
    send   = st.send;
    slot_a = st.sa;
    slot_b = st.sb;
    flip   = st.flip;
  end
endmodule

// File: rtl/echo_step_ctl.sv
module echo_step_ctl
  import echo_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             chan_drop,
  input  logic             rx_valid,
  input  logic             tx_ready,
  input  logic             flip,
  input  logic             send,
  output logic             rx_ready,
  output logic             tx_valid,
  output logic [POS_W-1:0] pos,
  output logic             dir,
  output logic             eor,
  output logic             line_done
);
  logic active;
  logic at_print;
  logic rx_fire;
  logic tx_fire;

  assign at_print  = (pos == POS_W'(PRINT_POS));
  assign rx_ready  = active && !dir && !at_print && !chan_drop;
  assign tx_valid  = active &&  dir && !at_print && !chan_drop;
  assign rx_fire   = rx_valid && rx_ready;
  assign tx_fire   = tx_valid && tx_ready;
  assign eor       = tx_fire && (pos == POS_W'(LAST_POS));
  assign line_done = active && (at_print || chan_drop);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      pos    <= '0;
      dir    <= 1'b0;
    end else if (!active) begin
      pos <= '0;
      dir <= 1'b0;
      if (go) active <= 1'b1;
    end else if (chan_drop) begin
      active <= 1'b0;
      pos    <= '0;
      dir    <= 1'b0;
    end else if (at_print) begin
      pos <= '0;
    end else if (rx_fire || tx_fire) begin
      pos <= pos + 1'b1;
      if (flip) dir <= !dir;
    end
  end

  AST_DIR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !at_print) |-> (dir == send)); // R8
  AST_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_ready && tx_valid)); // R8
  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= POS_W'(PRINT_POS)); // R11
  AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (active && at_print && !chan_drop) |=> (pos == '0) && active); // R11
  AST_EOR_POS: assert property (@(posedge clk) disable iff (!rst_n)
    eor |=> line_done || !active); // R10
  AST_DROP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && chan_drop) |=> !rx_ready && !tx_valid && (pos == '0)); // R12
endmodule

// File: rtl/echo_read_seq.sv
module echo_read_seq
  import echo_seq_pkg::*;
#(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              chan_drop,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  output logic              mem_we,
  output logic [SLOT_W-1:0] mem_slot,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [SLOT_W-1:0] mem_ra,
  output logic [SLOT_W-1:0] mem_rb,
  input  logic [DATA_W-1:0] mem_da,
  input  logic [DATA_W-1:0] mem_db,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  output logic              echo_dir,
  output logic              eor,
  output logic              line_done
);
  logic [POS_W-1:0]  pos;
  logic              send;
  logic              flip;
  logic [SLOT_W-1:0] sa;
  logic [SLOT_W-1:0] sb;

  echo_step_decode u_dec (
    .pos    (pos),
    .send   (send),
    .slot_a (sa),
    .slot_b (sb),
    .flip   (flip)
  );

  echo_step_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .chan_drop (chan_drop),
    .rx_valid  (rx_valid),
    .tx_ready  (tx_ready),
    .flip      (flip),
    .send      (send),
    .rx_ready  (rx_ready),
    .tx_valid  (tx_valid),
    .pos       (pos),
    .dir       (echo_dir),
    .eor       (eor),
    .line_done (line_done)
  );

  assign mem_we    = rx_valid && rx_ready;
  assign mem_slot  = sa;
  assign mem_wdata = rx_data;
  assign mem_ra    = sa;
  assign mem_rb    = sb;
  assign tx_data   = mem_da & mem_db;

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !chan_drop) |=> tx_valid && $stable(mem_ra) && $stable(mem_rb)); // R9
  AST_NO_WR_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    echo_dir |-> !mem_we); // R8
endmodule

// File: tb/sim_echo_read_seq.sv
module sim_echo_read_seq;
  localparam int W = 36;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0, chan_drop = 1'b0, rx_valid = 1'b0, tx_ready = 1'b0;
  logic [W-1:0] rx_data = '0;
  logic rx_ready, mem_we, tx_valid, echo_dir, eor, line_done;
  logic [4:0] mem_slot, mem_ra, mem_rb;
  logic [W-1:0] mem_wdata, mem_da, mem_db, tx_data;
  logic [W-1:0] mem [24];

  int checks = 0, fails = 0, cycles = 0;
  int bpos = 0, lines = 0;
  bit bact = 0, pend_done = 0;

  always #10 clk = !clk;

  always_comb begin
    mem_da = (mem_ra < 24) ? mem[mem_ra] : '0;
    mem_db = (mem_rb < 24) ? mem[mem_rb] : '0;
  end

  echo_read_seq #(.DATA_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .go(go), .chan_drop(chan_drop),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .mem_we(mem_we), .mem_slot(mem_slot), .mem_wdata(mem_wdata),
    .mem_ra(mem_ra), .mem_rb(mem_rb), .mem_da(mem_da), .mem_db(mem_db),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .echo_dir(echo_dir), .eor(eor), .line_done(line_done));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s pos=%0d actual=%0h expected=%0h", req, bpos, act, exp);
    end
  endtask

  function automatic void bsched(input int p, output bit e, output int a, output int b);
    e = 1; a = p - 28; b = p - 28;
    if (p <= 17) begin e = 0; a = p; end
    else case (p)
      18: begin a = 2;  b = 10; end
      19: begin a = 3;  b = 11; end
      20: begin e = 0; a = 18; end
      21: begin e = 0; a = 19; end
      22: begin a = 12; b = 2; end
      23: begin a = 13; b = 3; end
      24: begin e = 0; a = 20; end
      25: begin e = 0; a = 21; end
      26: begin a = 0; b = 0; end
      27: begin a = 1; b = 1; end
      28: begin e = 0; a = 22; end
      29: begin e = 0; a = 23; end
      default: ;
    endcase
  endfunction

  function automatic string req_of(input int p);
    if (p <= 17) return "R3";
    if (p <= 19) return "R4";
    if (p <= 23) return "R5";
    if (p <= 27) return "R6";
    return "R7";
  endfunction

  task automatic step(input bit iv, input bit ordy, input bit st, input bit dc);
    bit e; int a, b;
    logic [W-1:0] d;
    @(negedge clk);
    d = {$urandom, $urandom};
    rx_valid = iv; tx_ready = ordy; go = st; chan_drop = dc; rx_data = d;
    #1;
    if (!bact) begin
      chk(!rx_ready && !tx_valid && !mem_we && !line_done && !eor, "R1 idle", {rx_ready, tx_valid, line_done}, 0);
      if (st) begin bact = 1; bpos = 0; end
    end else if (dc) begin
      chk(line_done == 1, "R12 done on drop", line_done, 1);
      chk(!rx_ready && !tx_valid, "R12 no handshake", {rx_ready, tx_valid}, 0);
      bact = 0; bpos = 0; pend_done = 0;
    end else if (pend_done) begin
      chk(line_done == 1, "R11 line_done", line_done, 1);
      chk(!rx_ready && !tx_valid, "R11 quiet", {rx_ready, tx_valid}, 0);
      pend_done = 0; bpos = 0; lines++;
    end else begin
      bsched(bpos, e, a, b);
      chk(line_done == 0, "R11 no early done", line_done, 0);
      chk(echo_dir == e, "R8 direction", echo_dir, e);
      if (e) begin
        chk(tx_valid && !rx_ready, "R8 send side", {tx_valid, rx_ready}, 2'b10);
        chk(tx_data == (mem[a] & mem[b]), {req_of(bpos), " echo"}, tx_data, mem[a] & mem[b]);
        chk(eor == (ordy && bpos == 45), "R10 eor", eor, ordy && bpos == 45);
        if (ordy) begin
          bpos++;
          if (bpos == 46) pend_done = 1;
        end
      end else begin
        chk(rx_ready && !tx_valid, "R8 receive side", {rx_ready, tx_valid}, 2'b10);
        chk(mem_we == iv, "R3 write strobe", mem_we, iv);
        if (iv) begin
          chk(mem_slot == 5'(a), bpos == 0 ? "R2 first slot" : req_of(bpos), mem_slot, a);
          chk(mem_wdata == d, "R3 write data", mem_wdata, d);
          mem[a] = d;
          bpos++;
        end
      end
    end
  endtask

  task automatic run_rand(input int until_pos, input int until_lines);
    int guard = 0;
    while (bact && guard < 5000 && !(until_pos >= 0 && bpos == until_pos && !pend_done)
           && !(until_lines >= 0 && lines >= until_lines)) begin
      step(($urandom % 4) != 0, ($urandom % 4) != 0, 1'b0, 1'b0);
      guard++;
    end
  endtask

  initial begin
    while (cycles < 150000) begin @(posedge clk); cycles++; end
    fails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 24; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(!rx_ready && !tx_valid && !echo_dir && !eor && !line_done, "R1 reset state",
        {rx_ready, tx_valid, echo_dir, eor, line_done}, 0);
    @(negedge clk); rst_n = 1'b1;
    step(1, 1, 0, 0);
    step(0, 0, 0, 1);           // drop while idle has no effect (R12)
    step(1, 1, 1, 0);           // go
    // directed: stall on the first echo word for several cycles (R9)
    while (bpos < 18) step(1, 1, 0, 0);
    repeat (4) step(1, 0, 0, 0);
    run_rand(-1, 3);
    // drop during reading (R12)
    run_rand(10, -1);
    step(1, 1, 0, 1);
    step(1, 1, 0, 0);
    step(1, 1, 1, 0);
    // drop during the 8-3 echo (R12)
    run_rand(22, -1);
    step(1, 0, 0, 1);
    step(1, 1, 1, 0);
    lines = 0;
    run_rand(-1, 1);
    repeat (3) step(1, 1, 0, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule